// File: doc/BRIEF.md
# Pulse Capture and Interrupt Request Unit

This unit watches three active-low input lines for qualified falling pulses. The lines are sampled once per instruction-cycle strobe. Each line first passes through a two-flop synchronizer. A pulse counts only when the line has been seen high at one strobe and then low at the next two strobes. Each low period counts at most once.

The middle line is the interrupt line. When the interrupt-enable bit is set, a qualified pulse on it raises a pending request. The request is held until the sequencer acknowledges it at a safe point. A safe point means the current instruction is complete and no run of chained jumps or address loads is in progress.

On acceptance the unit asserts a take strobe with the fixed vector 0x0FF, so that the sequencer pushes the return address and jumps. In the same cycle it pulses a clear for the enable bit and passes on the skip-pending state so that it is saved with the return address. The outer two lines set sticky latches. A read command returns them on a 4-bit port and clears them on the same clock edge. The reset input is asynchronous, active low, and is expected to be released synchronously to the clock.

Top module: `edge_irq_unit`

## Requirements
- R1: An event on a line fires only when that line, after synchronization, was high at one cycle strobe and then low at the following two strobes. A low lasting only one strobe produces no event.
- R2: A line held low for many strobes produces exactly one event. It must return high at a strobe before another event can occur.
- R3: A line that is low when reset is released produces no event until it has been seen high at a strobe.
- R4: `rd_data_o` reads as follows:
  - bit 3 is the latch of line 2.
  - bit 2 is `aux_in` when `aux_gp_en` is 1, and 1 otherwise.
  - bit 1 is always 0.
  - bit 0 is the latch of line 0.
- R5: A clock cycle with `rd_i` high clears both latches at its closing edge. An event on a latched line at that same edge leaves its latch set.
- R6: An interrupt-line event while `ien_i` is 1 raises `req_o`, and `req_o` stays high until taken. An event while `ien_i` is 0 is dropped. A pending request is withdrawn when `ien_i` goes low.
- R7: `take_o` and `ien_clr_o` go high only in a cycle where a request is pending and both `ack_i` and `safe_pt_i` are 1. After that cycle `req_o` is 0. An acknowledge without a safe point leaves the request pending.
- R8: During `take_o`, `vec_o` reads 11'h0FF and `push_skip_o` equals `skip_i`.
- R9: Reset clears both latches and any pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle strobe, one clock wide |
| pins_n | input | 3 | Active-low lines: [0] latch line, [1] interrupt line, [2] latch line |
| aux_gp_en | input | 1 | Auxiliary pin is configured as a general input |
| aux_in | input | 1 | Auxiliary pin level |
| rd_i | input | 1 | Latch-read command |
| rd_data_o | output | 4 | Latch-read value |
| ien_i | input | 1 | Interrupt-enable bit |
| ien_clr_o | output | 1 | Clears the interrupt-enable bit |
| safe_pt_i | input | 1 | Sequencer is at an acceptable point |
| ack_i | input | 1 | Sequencer acknowledges the request |
| skip_i | input | 1 | Current skip-pending state |
| req_o | output | 1 | Pending interrupt request (level) |
| take_o | output | 1 | Acceptance strobe: push return address, load vector |
| vec_o | output | 11 | Interrupt vector address |
| push_skip_o | output | 1 | Skip state to store with the return address |

## Verification
A pin change becomes visible to the qualifier after two clock edges of synchronization. The bench therefore changes pins only at the falling clock edge and places the next strobe three clocks later. Latch and request results are registered at the edge of the second qualifying low strobe, so they are read at the falling edge that follows that strobe. The take strobe, the enable clear, the vector and the skip output are combinational on `ack_i` and `safe_pt_i`, and are sampled 1 ns after those inputs are driven. The effects of a take or a read are checked at the next falling edge. Pulse widths from one to four strobes are swept on each line, and every combination of the auxiliary inputs is covered.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int NLINES    = 3;
  localparam int LINE_LAT0 = 0;
  localparam int LINE_IRQ  = 1;
  localparam int LINE_LAT3 = 2;
  localparam int NLAT      = 2;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  // reset to the idle (high) level of the active-low lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/pulse_qual.sv
module pulse_qual #(
  parameter int LOW_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic lvl,
  output logic evt
);
  localparam int CW = $clog2(LOW_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(LOW_CYC - 1);

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          evt_c;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    evt_c   = 1'b0;
    if (cyc_en) begin
      if (lvl) begin
        armed_d = 1'b1;
        cnt_d   = '0;
      end else if (armed_q) begin
        if (cnt_q == LAST) begin
          evt_c   = 1'b1;
          armed_d = 1'b0;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cyc_en) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign evt = evt_c;
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int              PC_W   = 11,
  parameter logic [PC_W-1:0] VECTOR = PC_W'(255)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt,
  input  logic            ien_i,
  input  logic            safe_pt_i,
  input  logic            ack_i,
  input  logic            skip_i,
  output logic            req_o,
  output logic            take_o,
  output logic            ien_clr_o,
  output logic [PC_W-1:0] vec_o,
  output logic            push_skip_o
);
  logic pend_q, pend_d;
  logic take_c;

  always_comb begin
    take_c = pend_q & ack_i & safe_pt_i;
    pend_d = ien_i & ~take_c & (pend_q | evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign req_o       = pend_q;
  assign take_o      = take_c;
  assign ien_clr_o   = take_c;
  assign vec_o       = VECTOR;
  assign push_skip_o = take_c & skip_i;
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import edge_irq_pkg::*;
#(
  parameter int              LOW_CYC = 2,
  parameter int              PC_W    = 11,
  parameter logic [PC_W-1:0] VECTOR  = PC_W'(255)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_en,
  input  logic [2:0]      pins_n,
  input  logic            aux_gp_en,
  input  logic            aux_in,
  input  logic            rd_i,
  output logic [3:0]      rd_data_o,
  input  logic            ien_i,
  output logic            ien_clr_o,
  input  logic            safe_pt_i,
  input  logic            ack_i,
  input  logic            skip_i,
  output logic            req_o,
  output logic            take_o,
  output logic [PC_W-1:0] vec_o,
  output logic            push_skip_o
);
  logic [NLINES-1:0] lvl;
  logic [NLINES-1:0] evt;
  logic [NLAT-1:0]   lat_q, lat_d;
  logic [NLAT-1:0]   lat_evt;

  pin_sync #(.W(NLINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins_n),
    .q    (lvl)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_qual
    pulse_qual #(.LOW_CYC(LOW_CYC)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .cyc_en(cyc_en),
      .lvl   (lvl[i]),
      .evt   (evt[i])
    );
  end

  assign lat_evt = {evt[LINE_LAT3], evt[LINE_LAT0]};

  always_comb begin
    lat_d = (lat_q & ~{NLAT{rd_i}}) | lat_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  assign rd_data_o = {lat_q[1], (aux_gp_en ? aux_in : 1'b1), 1'b0, lat_q[0]};

  irq_gate #(.PC_W(PC_W), .VECTOR(VECTOR)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt[LINE_IRQ]),
    .ien_i      (ien_i),
    .safe_pt_i  (safe_pt_i),
    .ack_i      (ack_i),
    .skip_i     (skip_i),
    .req_o      (req_o),
    .take_o     (take_o),
    .ien_clr_o  (ien_clr_o),
    .vec_o      (vec_o),
    .push_skip_o(push_skip_o)
  );
endmodule

// File: rtl/edge_irq_unit_chk.sv
module edge_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_en,
  input logic       ien_i,
  input logic       rd_i,
  input logic       req_o,
  input logic       take_o,
  input logic       ien_clr_o,
  input logic [1:0] lat_q,
  input logic [2:0] evt
);
  assert_evt_on_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != 3'b000) |-> cyc_en);

  assert_evt_single0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> !evt[0]);
  assert_evt_single1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt[1] |=> !evt[1]);
  assert_evt_single2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt[2] |=> !evt[2]);

  assert_read_clear0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !evt[0]) |=> !lat_q[0]);
  assert_read_clear3_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !evt[2]) |=> !lat_q[1]);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !take_o && ien_i) |=> req_o);
  assert_req_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_i |=> !req_o);

  assert_take_drops_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !req_o);
  assert_clr_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ien_clr_o |-> req_o);
endmodule

bind edge_irq_unit edge_irq_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cyc_en   (cyc_en),
  .ien_i    (ien_i),
  .rd_i     (rd_i),
  .req_o    (req_o),
  .take_o   (take_o),
  .ien_clr_o(ien_clr_o),
  .lat_q    (lat_q),
  .evt      (evt)
);

// File: tb/edge_irq_unit_test.sv
module edge_irq_unit_test;
  logic        clk;
  logic        rst_n;
  logic        cyc_en;
  logic [2:0]  pins_n;
  logic        aux_gp_en;
  logic        aux_in;
  logic        rd_i;
  logic [3:0]  rd_data_o;
  logic        ien_i;
  logic        ien_clr_o;
  logic        safe_pt_i;
  logic        ack_i;
  logic        skip_i;
  logic        req_o;
  logic        take_o;
  logic [10:0] vec_o;
  logic        push_skip_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  edge_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .pins_n(pins_n),
    .aux_gp_en(aux_gp_en), .aux_in(aux_in), .rd_i(rd_i), .rd_data_o(rd_data_o),
    .ien_i(ien_i), .ien_clr_o(ien_clr_o), .safe_pt_i(safe_pt_i), .ack_i(ack_i),
    .skip_i(skip_i), .req_o(req_o), .take_o(take_o), .vec_o(vec_o),
    .push_skip_o(push_skip_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pins change at a falling edge; the strobe comes three clocks later
  task automatic strobe(input bit rd);
    repeat (3) @(negedge clk);
    cyc_en = 1'b1;
    rd_i   = rd;
    @(negedge clk);
    cyc_en = 1'b0;
    rd_i   = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic pulse(input int line, input int w);
    pins_n[line] = 1'b1;
    strobe(1'b0);
    pins_n[line] = 1'b0;
    for (int k = 0; k < w; k++) strobe(1'b0);
    pins_n[line] = 1'b1;
    strobe(1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cyc_en = 1'b0; pins_n = 3'b000; aux_gp_en = 1'b0; aux_in = 1'b0;
    rd_i = 1'b0; ien_i = 1'b0; safe_pt_i = 1'b0; ack_i = 1'b0; skip_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset rd_data", int'(rd_data_o), 4);
    check("R9 reset req", int'(req_o), 0);
    rst_n = 1'b1;

    // R3: lines low out of reset, never seen high
    ien_i = 1'b1;
    for (int k = 0; k < 4; k++) strobe(1'b0);
    check("R3 no latch while low from reset", int'(rd_data_o), 4);
    check("R3 no request while low from reset", int'(req_o), 0);
    pins_n = 3'b111;
    strobe(1'b0);
    ien_i = 1'b0;

    // R1 width sweep on both latched lines
    for (int w = 1; w <= 4; w++) begin
      pulse(0, w);
      check($sformatf("R1 line0 width %0d", w), int'(rd_data_o[0]), (w >= 2) ? 1 : 0);
      check($sformatf("R1 line2 quiet width %0d", w), int'(rd_data_o[3]), 0);
      do_read();
      check($sformatf("R5 line0 cleared width %0d", w), int'(rd_data_o), 4);
      pulse(2, w);
      check($sformatf("R1 line2 width %0d", w), int'(rd_data_o[3]), (w >= 2) ? 1 : 0);
      check($sformatf("R4 line2 image width %0d", w), int'(rd_data_o), (w >= 2) ? 12 : 4);
      do_read();
      check($sformatf("R5 line2 cleared width %0d", w), int'(rd_data_o), 4);
    end

    // R4 both latches set together
    pins_n = 3'b111; strobe(1'b0);
    pins_n = 3'b010; strobe(1'b0); strobe(1'b0);
    pins_n = 3'b111; strobe(1'b0);
    check("R4 both latches", int'(rd_data_o), 13);
    for (int a = 0; a < 4; a++) begin
      aux_gp_en = a[1];
      aux_in    = a[0];
      #1;
      check($sformatf("R4 aux combo %0d", a), int'(rd_data_o[2]), a[1] ? a[0] : 1);
      check($sformatf("R4 bit1 zero combo %0d", a), int'(rd_data_o[1]), 0);
    end
    aux_gp_en = 1'b0;
    do_read();
    check("R5 both cleared", int'(rd_data_o), 4);

    // R2: long low gives one event only
    pins_n[0] = 1'b1; strobe(1'b0);
    pins_n[0] = 1'b0; strobe(1'b0); strobe(1'b0);
    check("R2 first event", int'(rd_data_o[0]), 1);
    do_read();
    for (int k = 0; k < 4; k++) strobe(1'b0);
    check("R2 no second event while low", int'(rd_data_o[0]), 0);
    pins_n[0] = 1'b1; strobe(1'b0);

    // R5 read in the same edge as an event
    pins_n[0] = 1'b0; strobe(1'b0);
    strobe(1'b1);
    check("R5 event wins over same-edge read", int'(rd_data_o[0]), 1);
    pins_n[0] = 1'b1;
    do_read();
    check("R5 cleared after", int'(rd_data_o[0]), 0);

    // R6 request with enable
    ien_i = 1'b1;
    pulse(1, 2);
    check("R6 request raised", int'(req_o), 1);
    check("R6 latches untouched by irq line", int'(rd_data_o), 4);
    @(negedge clk); ack_i = 1'b1; safe_pt_i = 1'b0; skip_i = 1'b1;
    #1;
    check("R7 no take without safe point", int'(take_o), 0);
    check("R7 no clear without safe point", int'(ien_clr_o), 0);
    @(negedge clk);
    check("R7 request held", int'(req_o), 1);
    safe_pt_i = 1'b1;
    #1;
    check("R7 take", int'(take_o), 1);
    check("R7 enable clear", int'(ien_clr_o), 1);
    check("R8 vector", int'(vec_o), 255);
    check("R8 skip saved 1", int'(push_skip_o), 1);
    @(negedge clk);
    ack_i = 1'b0; safe_pt_i = 1'b0;
    check("R7 request dropped", int'(req_o), 0);

    // R8 with skip 0
    pulse(1, 3);
    check("R6 request again", int'(req_o), 1);
    repeat (5) @(negedge clk);
    check("R6 request stays", int'(req_o), 1);
    skip_i = 1'b0; ack_i = 1'b1; safe_pt_i = 1'b1;
    #1;
    check("R8 skip saved 0", int'(push_skip_o), 0);
    check("R8 vector again", int'(vec_o), 255);
    @(negedge clk);
    ack_i = 1'b0; safe_pt_i = 1'b0;
    check("R7 dropped again", int'(req_o), 0);

    // R1 short irq pulse
    pulse(1, 1);
    check("R1 short irq pulse ignored", int'(req_o), 0);

    // R6 event while disabled
    ien_i = 1'b0;
    pulse(1, 2);
    check("R6 disabled event dropped", int'(req_o), 0);
    ien_i = 1'b1;
    @(negedge clk);
    check("R6 no late request", int'(req_o), 0);

    // R6 withdraw on enable low
    pulse(1, 2);
    check("R6 pending", int'(req_o), 1);
    ien_i = 1'b0;
    @(negedge clk);
    check("R6 withdrawn", int'(req_o), 0);

    // R9 reset mid-run
    ien_i = 1'b1;
    pulse(0, 2);
    pulse(1, 2);
    check("R9 setup latch", int'(rd_data_o[0]), 1);
    check("R9 setup req", int'(req_o), 1);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R9 latches cleared", int'(rd_data_o), 4);
    check("R9 request cleared", int'(req_o), 0);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule